// File: doc/BRIEF.md
# Nibble-Carry 8-bit Arithmetic Unit

This block is a purely combinational arithmetic unit for a small 8-bit processor core. It takes two operands, a 2-bit operation code and the current four-bit flag set. In the same cycle it returns the 8-bit result and the next flag set. It supports four operations: add, subtract, increment by one and decrement by one. Every result wraps modulo 256.

The flag set is ordered Z, N, H, C from its most significant bit to its least significant bit. H reports a carry or borrow across the boundary between the low nibble and the high nibble. Add and subtract rewrite C. Increment and decrement copy the incoming C through unchanged and ignore the second operand. A byte view of the flags is also provided, with the nibble in bits 7:4 and zeros in bits 3:0, so the surrounding core can store it directly as its flag register.

The operation code is 00 for add, 01 for subtract, 10 for increment and 11 for decrement. Internally there are no stored states and only one evaluation path. An operand-select stage chooses the addend and the carry-in. A split adder produces the sum together with the nibble carry and the top carry. A flag stage maps those carries to H and C for the selected operation.

Top module: `alu8_nib`

## Requirements
- R1: With op_sel = 00 (add), res equals (opa + opb) mod 256.
- R2: With op_sel = 01 (subtract), res equals (opa - opb) mod 256.
- R3: With op_sel = 10 (increment) or 11 (decrement), res equals (opa + 1) mod 256 or (opa - 1) mod 256 respectively, whatever the value of opb.
- R4: flg_out[3] (Z) is 1 exactly when res is 0x00.
- R5: flg_out[2] (N) is 1 for subtract and decrement, and 0 for add and increment.
- R6: flg_out[1] (H) for add is 1 when opa[3:0] + opb[3:0] is at least 0x10. For increment it is 1 when opa[3:0] is 0xF. So incrementing 0x0F sets H and incrementing 0x0A does not.
- R7: flg_out[1] (H) for subtract is 1 when opa[3:0] < opb[3:0]. For decrement it is 1 when opa[3:0] is 0x0. So decrementing 0x10 sets H and decrementing 0x0B does not.
- R8: flg_out[0] (C) for add is 1 when the 9-bit sum opa + opb exceeds 0xFF. For subtract it is 1 when opa < opb.
- R9: For increment and decrement, flg_out[0] equals flg_in[0]. flg_in[3:1] never affects any output.
- R10: f_byte equals {flg_out, 4'b0000}.
- R11: Wrap corners: incrementing 0xFF gives 0x00 with Z and H set, and decrementing 0x00 gives 0xFF with N and H set and Z clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | First operand; the only operand for increment and decrement |
| opb | input | 8 | Second operand, used by add and subtract |
| op_sel | input | 2 | Operation code: 00 add, 01 subtract, 10 increment, 11 decrement |
| flg_in | input | 4 | Current flags {Z,N,H,C}; only C is read, and only by increment and decrement |
| res | output | 8 | Wrapped 8-bit result |
| flg_out | output | 4 | Next flags {Z,N,H,C} |
| f_byte | output | 8 | Flags packed as a register byte, nibble in bits 7:4 |

## Verification
The unit holds no state, so an internal fault shows at the ports in the same evaluation as the stimulus that exercises it. A wrongly inverted carry-in or addend corrupts res on every subtract or decrement. A wrong nibble-carry polarity corrupts H only when the low nibbles straddle the boundary. A carry that is written when it should be kept shows only for increment or decrement with flg_in[0] differing from the computed carry. For this reason, every operand pair is exercised under all four operations, with the incoming C driven to both values, and directed corner vectors pin down the wrap and boundary cases.

// File: rtl/alu8_nib_pkg.sv
package alu8_nib_pkg;

    // Operation codes; the encoding is part of the port contract
    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_INC = 2'b10,
        ALU_DEC = 2'b11
    } alu_op_e;

    // Flag set, most significant first: Z, N, H, C
    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } alu_flags_t;

    localparam int FLAG_W = 4;

endpackage

// File: rtl/alu8_opnd_sel.sv
module alu8_opnd_sel
    import alu8_nib_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   opb,
    output logic [DATA_W-1:0]   addend,
    output logic                carry_in,
    output logic                is_sub,
    output logic                keep_c
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Subtraction is done as a + ~b + 1; unit steps use a constant one
    always_comb begin
        unique case (op)
            ALU_ADD: begin
                addend   = opb;
                carry_in = 1'b0;
                is_sub   = 1'b0;
                keep_c   = 1'b0;
            end
            ALU_SUB: begin
                addend   = ~opb;
                carry_in = 1'b1;
                is_sub   = 1'b1;
                keep_c   = 1'b0;
            end
            ALU_INC: begin
                addend   = ONE;
                carry_in = 1'b0;
                is_sub   = 1'b0;
                keep_c   = 1'b1;
            end
            ALU_DEC: begin
                addend   = ~ONE;
                carry_in = 1'b1;
                is_sub   = 1'b1;
                keep_c   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/alu8_split_adder.sv
module alu8_split_adder #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              nib_co,
    output logic              top_co
);

    localparam int HI_W = DATA_W - NIB_W;

    logic [NIB_W:0] lo_sum;
    logic [HI_W:0]  hi_sum;

    // Two segments so the carry across the nibble boundary is visible
    always_comb begin
        lo_sum = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]}
               + {{NIB_W{1'b0}}, cin};
        hi_sum = {1'b0, a[DATA_W-1:NIB_W]} + {1'b0, b[DATA_W-1:NIB_W]}
               + {{HI_W{1'b0}}, lo_sum[NIB_W]};
    end

    assign sum    = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
    assign nib_co = lo_sum[NIB_W];
    assign top_co = hi_sum[HI_W];

endmodule

// File: rtl/alu8_flag_gen.sv
module alu8_flag_gen
    import alu8_nib_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] sum,
    input  logic              nib_co,
    input  logic              top_co,
    input  logic              is_sub,
    input  logic              keep_c,
    input  alu_flags_t        flags_cur,
    output alu_flags_t        flags_nxt
);

    logic unused_flag_bits;
    assign unused_flag_bits = ^{flags_cur.z, flags_cur.n, flags_cur.h};

    // In a + ~b + 1 a missing carry out means a borrow
    always_comb begin
        flags_nxt.z = ~|sum;
        flags_nxt.n = is_sub;
        flags_nxt.h = is_sub ? ~nib_co : nib_co;
        if (keep_c) flags_nxt.c = flags_cur.c;
        else        flags_nxt.c = is_sub ? ~top_co : top_co;
    end

endmodule

// File: rtl/alu8_nib.sv
module alu8_nib
    import alu8_nib_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [1:0]        op_sel,
    input  logic [3:0]        flg_in,
    output logic [DATA_W-1:0] res,
    output logic [3:0]        flg_out,
    output logic [DATA_W-1:0] f_byte
);

    localparam int PAD_W = DATA_W - FLAG_W;

    alu_op_e           op;
    logic [DATA_W-1:0] addend;
    logic              carry_in;
    logic              is_sub;
    logic              keep_c;
    logic              nib_co;
    logic              top_co;
    alu_flags_t        fl_cur;
    alu_flags_t        fl_nxt;

    assign op     = alu_op_e'(op_sel);
    assign fl_cur = alu_flags_t'(flg_in);

    alu8_opnd_sel #(.DATA_W(DATA_W)) u_sel (
        .op       (op),
        .opb      (opb),
        .addend   (addend),
        .carry_in (carry_in),
        .is_sub   (is_sub),
        .keep_c   (keep_c)
    );

    alu8_split_adder #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_add (
        .a      (opa),
        .b      (addend),
        .cin    (carry_in),
        .sum    (res),
        .nib_co (nib_co),
        .top_co (top_co)
    );

    alu8_flag_gen #(.DATA_W(DATA_W)) u_flg (
        .sum       (res),
        .nib_co    (nib_co),
        .top_co    (top_co),
        .is_sub    (is_sub),
        .keep_c    (keep_c),
        .flags_cur (fl_cur),
        .flags_nxt (fl_nxt)
    );

    assign flg_out = fl_nxt;
    assign f_byte  = {fl_nxt, {PAD_W{1'b0}}};

endmodule

// File: rtl/alu8_nib_chk.sv
module alu8_nib_chk #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [1:0]        op_sel,
    input logic [3:0]        flg_in,
    input logic [DATA_W-1:0] res,
    input logic [3:0]        flg_out,
    input logic [DATA_W-1:0] f_byte
);

    logic [DATA_W:0]  wide_add;
    logic [NIB_W:0]   nib_add;
    logic [DATA_W-1:0] exp_res;

    always_comb begin
        wide_add = {1'b0, opa} + {1'b0, opb};
        nib_add  = {1'b0, opa[NIB_W-1:0]} + {1'b0, opb[NIB_W-1:0]};
        case (op_sel)
            2'b00:   exp_res = wide_add[DATA_W-1:0];
            2'b01:   exp_res = opa - opb;
            2'b10:   exp_res = opa + DATA_W'(1);
            default: exp_res = opa - DATA_W'(1);
        endcase
    end

    always_comb begin
        if (!$isunknown({opa, opb, op_sel, flg_in})) begin
            assert_result_R1_R2_R3: assert (res == exp_res);
            assert_zero_R4: assert (flg_out[3] == (res == '0));
            assert_neg_R5: assert (flg_out[2] == op_sel[0]);
            if (op_sel == 2'b00) begin
                assert_half_add_R6: assert (flg_out[1] == nib_add[NIB_W]);
                assert_carry_add_R8: assert (flg_out[0] == wide_add[DATA_W]);
            end
            if (op_sel == 2'b01) begin
                assert_half_sub_R7: assert (flg_out[1] == (opa[NIB_W-1:0] < opb[NIB_W-1:0]));
                assert_carry_sub_R8: assert (flg_out[0] == (opa < opb));
            end
            if (op_sel[1]) begin
                assert_keep_carry_R9: assert (flg_out[0] == flg_in[0]);
            end
            assert_fbyte_R10: assert (f_byte[DATA_W-1 -: 4] == flg_out && f_byte[DATA_W-5:0] == '0);
        end
    end

endmodule

bind alu8_nib alu8_nib_chk #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_chk (
    .opa     (opa),
    .opb     (opb),
    .op_sel  (op_sel),
    .flg_in  (flg_in),
    .res     (res),
    .flg_out (flg_out),
    .f_byte  (f_byte)
);

// File: tb/alu8_nib_tb.sv
module alu8_nib_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;
    localparam int NVEC       = 14;

    // {op[2], a[8], b[8], flags_in[4], res[8], flags_out[4]}
    localparam logic [33:0] VEC [NVEC] = '{
        {2'b00, 8'h0A, 8'h01, 4'h0, 8'h0B, 4'h0},
        {2'b10, 8'h0A, 8'h00, 4'hA, 8'h0B, 4'h0},
        {2'b11, 8'h0B, 8'h00, 4'h0, 8'h0A, 4'h4},
        {2'b10, 8'h0F, 8'h00, 4'h0, 8'h10, 4'h2},
        {2'b11, 8'h10, 8'h00, 4'h0, 8'h0F, 4'h6},
        {2'b10, 8'hFF, 8'h00, 4'h1, 8'h00, 4'hB},
        {2'b11, 8'h00, 8'h00, 4'h0, 8'hFF, 4'h6},
        {2'b00, 8'hFF, 8'h01, 4'h0, 8'h00, 4'hB},
        {2'b01, 8'h10, 8'h20, 4'h0, 8'hF0, 4'h5},
        {2'b01, 8'h3C, 8'h3C, 4'h0, 8'h00, 4'hC},
        {2'b00, 8'h80, 8'h80, 4'h0, 8'h00, 4'h9},
        {2'b11, 8'h01, 8'h00, 4'hF, 8'h00, 4'hD},
        {2'b10, 8'h7F, 8'h55, 4'h0, 8'h80, 4'h2},
        {2'b01, 8'h05, 8'h0E, 4'h0, 8'hF7, 4'h7}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opa = 8'h00;
    logic [7:0] opb = 8'h00;
    logic [1:0] op_sel = 2'b00;
    logic [3:0] flg_in = 4'h0;
    logic [7:0] res;
    logic [3:0] flg_out;
    logic [7:0] f_byte;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_nib u_dut (
        .opa     (opa),
        .opb     (opb),
        .op_sel  (op_sel),
        .flg_in  (flg_in),
        .res     (res),
        .flg_out (flg_out),
        .f_byte  (f_byte)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: op=%0d a=%02h b=%02h fin=%h actual=%0h expected=%0h",
                     tag, op_sel, opa, opb, flg_in, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] o, input logic [7:0] a,
                         input logic [7:0] b, input logic [3:0] f);
        op_sel = o; opa = a; opb = b; flg_in = f;
        #2;
    endtask

    // Independent model written from the requirements
    task automatic model(output logic [7:0] r, output logic [3:0] fl);
        int ai, bi, s;
        logic z, n, h, c;
        ai = int'(opa); bi = int'(opb);
        case (op_sel)
            2'b00: begin s = ai + bi; h = ((ai % 16) + (bi % 16)) >= 16; c = s > 255; end
            2'b01: begin s = ai - bi; h = (ai % 16) < (bi % 16); c = ai < bi; end
            2'b10: begin s = ai + 1; h = (ai % 16) == 15; c = flg_in[0]; end
            default: begin s = ai - 1; h = (ai % 16) == 0; c = flg_in[0]; end
        endcase
        r = 8'((s + 256) % 256);
        z = (r == 8'h00);
        n = op_sel[0];
        fl = {z, n, h, c};
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        logic [7:0] er, r0;
        logic [3:0] ef;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state with all-zero inputs: add of zeros gives zero, Z set (R4, R10)
        apply(2'b00, 8'h00, 8'h00, 4'h0);
        check("R1 reset res", res, 0);
        check("R4 reset flags", flg_out, 4'h8);
        check("R10 reset fbyte", f_byte, 8'h80);

        // Table of directed vectors (R6, R7, R9, R11 corners)
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][33:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:12]);
            check("R11 table res", res, VEC[i][11:4]);
            check("R6 R7 table flags", flg_out, VEC[i][3:0]);
            check("R10 table fbyte", f_byte, {VEC[i][3:0], 4'h0});
        end

        // opb ignored for unit steps: same opa, opb at both extremes (R3)
        apply(2'b10, 8'h3E, 8'h00, 4'h0); r0 = res;
        apply(2'b10, 8'h3E, 8'hFF, 4'h0);
        check("R3 inc opb ignored", res, r0);
        apply(2'b11, 8'h3E, 8'hFF, 4'h0);
        check("R3 dec res", res, 8'h3D);

        // Upper input flags do not leak (R9)
        apply(2'b00, 8'h12, 8'h34, 4'hE);
        check("R9 upper flags ignored", flg_out, 4'h0);

        // Exhaustive sweep, incoming C toggled per pair
        for (int o = 0; o < 4; o++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    apply(2'(o), 8'(a), 8'(b), {3'b000, 1'(a ^ b)});
                    model(er, ef);
                    case (o)
                        0: check("R1 add res", res, er);
                        1: check("R2 sub res", res, er);
                        default: check("R3 step res", res, er);
                    endcase
                    check("R4 Z", flg_out[3], ef[3]);
                    check("R5 N", flg_out[2], ef[2]);
                    if (o[0]) check("R7 H", flg_out[1], ef[1]);
                    else      check("R6 H", flg_out[1], ef[1]);
                    if (o[1]) check("R9 C kept", flg_out[0], ef[0]);
                    else      check("R8 C", flg_out[0], ef[0]);
                end
            end
        end
        report();
    end

endmodule